// File: doc/BRIEF.md
# E1 Per-Timeslot Transmit Code Inserter

This block sits in the transmit serial path of an E1 framer and chooses, one timeslot at a time, where each outgoing byte comes from. A frame has 32 timeslots of 8 bits each. For every timeslot the block sends one of four sources: the transmit serial input, a single idle byte shared by all timeslots, a byte programmed for that timeslot alone, or the receive-side framer output, which gives per-channel loopback.

Software programs the choices through a synchronous byte-wide write port. There are two 32-bit enable bitmaps, each split across four byte registers. There is also a shared idle byte, 32 per-timeslot bytes and a control register that holds the loopback-mode bit. A frame-sync pulse aligns the internal timeslot and bit counters. The choice for each timeslot is fixed at its first bit, so a write never splits a byte. The output is registered.

Top module: `e1_code_inserter`

## Requirements
- R1: While `rst_n` is low, `ser_out` is 0. After reset every register is 0, so `ser_out` repeats `ser_in`.
- R2: The cycle in which `fsync` is high carries bit 7 of timeslot 1. The position then advances by one bit per clock, 8 bits per timeslot, and wraps from timeslot 32 back to timeslot 1. A pulse in mid-byte realigns the position at once.
- R3: Timeslot n has an idle-enable bit at address 0x26 + (n-1)/8, bit (n-1)%8. When that bit is 1 and loopback mode is off, the timeslot carries the idle byte held at address 0x2A, sent bit 7 first.
- R4: Timeslot n has a code-enable bit at address 0x22 + (n-1)/8, bit (n-1)%8. When that bit is 1, the timeslot carries the byte held at address 0x5F + n, sent bit 7 first.
- R5: When a timeslot has its code-enable bit set, its own byte wins over its idle-enable bit, in either loopback mode.
- R6: Loopback mode is bit 5 of address 0x1B. When it is set, an idle-enable bit of 1 makes the timeslot carry `lb_in`, and a 0 makes it carry `ser_in`.
- R7: A register write only changes the timeslot that begins after the write cycle. A write that lands in the first-bit cycle of a timeslot does not affect that timeslot. A timeslot already being sent keeps its source and its byte until it ends.
- R8: `ser_out` shows the bit chosen in the previous cycle. A bit taken from `ser_in` or `lb_in` appears exactly one clock after it is sampled.
- R9: A write to an address outside the map has no effect on the output. Neither do writes to bits of 0x1B other than bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame-sync pulse marking bit 7 of timeslot 1 |
| ser_in | input | 1 | Transmit serial data input |
| lb_in | input | 1 | Receive-side framer serial output, used for loopback |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| ser_out | output | 1 | Transmit serial data output, registered |

## Verification
Two events can fall in the same cycle: a register write, and the latching of a timeslot's source and byte on its first bit. The bench provokes this by writing a different register with fresh data on every cycle for several frames. Many of these writes land on first-bit cycles, and some land on a `fsync` pulse in mid-byte. A reference model latches from its register copy before it applies that cycle's write. The scoreboard then compares every output bit with the model, so a write that leaks into the current timeslot shows up as a mismatch.

// File: rtl/e1ci_pkg.sv
package e1ci_pkg;
  localparam int NUM_CH = 32;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;
  localparam int LB_BIT = 5;

  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h1B;
  localparam logic [ADDR_W-1:0] A_CEN0  = 8'h22;
  localparam logic [ADDR_W-1:0] A_IEN0  = 8'h26;
  localparam logic [ADDR_W-1:0] A_IDLE  = 8'h2A;
  localparam logic [ADDR_W-1:0] A_CODE0 = 8'h60;

  typedef enum logic [1:0] {
    SRC_SER  = 2'd0,
    SRC_IDLE = 2'd1,
    SRC_CODE = 2'd2,
    SRC_LB   = 2'd3
  } src_e;
endpackage

// File: rtl/e1ci_slot_cnt.sv
module e1ci_slot_cnt #(
  parameter int NCH = e1ci_pkg::NUM_CH,
  parameter int BW  = e1ci_pkg::BYTE_W,
  localparam int CHW = $clog2(NCH),
  localparam int BTW = $clog2(BW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fsync_i,
  output logic [CHW-1:0] ch_o,
  output logic [BTW-1:0] bit_o,
  output logic           bound_o
);
  localparam logic [BTW-1:0] BIT_MAX = BTW'(BW - 1);
  localparam logic [CHW-1:0] CH_MAX  = CHW'(NCH - 1);

  logic [CHW-1:0] ch_q, ch_d;
  logic [BTW-1:0] bit_q, bit_d;

  // current position: a sync pulse forces timeslot 0, first bit
  always_comb begin
    ch_o    = fsync_i ? '0 : ch_q;
    bit_o   = fsync_i ? '0 : bit_q;
    bound_o = (bit_o == '0);
    bit_d   = (bit_o == BIT_MAX) ? '0 : bit_o + 1'b1;
    if (bit_o == BIT_MAX) begin
      ch_d = (ch_o == CH_MAX) ? '0 : ch_o + 1'b1;
    end else begin
      ch_d = ch_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q  <= '0;
      bit_q <= '0;
    end else begin
      ch_q  <= ch_d;
      bit_q <= bit_d;
    end
  end

  AST_FSYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_i |=> (bit_q == BTW'(1) && ch_q == '0)); // R2
  AST_CH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync_i && bit_q == BIT_MAX && ch_q != CH_MAX) |=> (ch_q == $past(ch_q) + 1'b1)); // R2
endmodule

// File: rtl/e1ci_regfile.sv
module e1ci_regfile #(
  parameter int NCH = e1ci_pkg::NUM_CH,
  parameter int BW  = e1ci_pkg::BYTE_W,
  parameter int AW  = e1ci_pkg::ADDR_W,
  localparam int NBANK = NCH / BW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en_i,
  input  logic [AW-1:0]           wr_addr_i,
  input  logic [BW-1:0]           wr_data_i,
  output logic [NCH-1:0]          idle_en_o,
  output logic [NCH-1:0]          code_en_o,
  output logic [BW-1:0]           idle_code_o,
  output logic                    lb_mode_o,
  output logic [NCH-1:0][BW-1:0]  codes_o
);
  import e1ci_pkg::*;

  logic [NBANK-1:0] ien_we, cen_we;
  logic [NCH-1:0]   code_we;
  logic             idle_we, ctrl_we;

  // write decode
  for (genvar g = 0; g < NBANK; g++) begin : g_bank_dec
    assign ien_we[g] = wr_en_i && (wr_addr_i == AW'(A_IEN0 + g));
    assign cen_we[g] = wr_en_i && (wr_addr_i == AW'(A_CEN0 + g));
  end
  for (genvar c = 0; c < NCH; c++) begin : g_code_dec
    assign code_we[c] = wr_en_i && (wr_addr_i == AW'(A_CODE0 + c));
  end
  assign idle_we = wr_en_i && (wr_addr_i == A_IDLE);
  assign ctrl_we = wr_en_i && (wr_addr_i == A_CTRL);

  // storage, one clock enable per register
  for (genvar g = 0; g < NBANK; g++) begin : g_bank_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idle_en_o[g*BW +: BW] <= '0;
      end else if (ien_we[g]) begin
        idle_en_o[g*BW +: BW] <= wr_data_i;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_en_o[g*BW +: BW] <= '0;
      end else if (cen_we[g]) begin
        code_en_o[g*BW +: BW] <= wr_data_i;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_code_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        codes_o[c] <= '0;
      end else if (code_we[c]) begin
        codes_o[c] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_code_o <= '0;
    end else if (idle_we) begin
      idle_code_o <= wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_mode_o <= 1'b0;
    end else if (ctrl_we) begin
      lb_mode_o <= wr_data_i[LB_BIT];
    end
  end

  AST_LOW_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i < A_CTRL) |=>
      $stable({idle_en_o, code_en_o, idle_code_o, lb_mode_o, codes_o})); // R9
endmodule

// File: rtl/e1ci_byte_sel.sv
module e1ci_byte_sel #(
  parameter int NCH = e1ci_pkg::NUM_CH,
  parameter int BW  = e1ci_pkg::BYTE_W,
  localparam int CHW = $clog2(NCH),
  localparam int BTW = $clog2(BW)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bound_i,
  input  logic [CHW-1:0]         ch_i,
  input  logic [BTW-1:0]         bit_i,
  input  logic [NCH-1:0]         idle_en_i,
  input  logic [NCH-1:0]         code_en_i,
  input  logic [BW-1:0]          idle_code_i,
  input  logic                   lb_mode_i,
  input  logic [NCH-1:0][BW-1:0] codes_i,
  input  logic                   ser_i,
  input  logic                   lb_i,
  output logic                   ser_o
);
  import e1ci_pkg::*;

  localparam logic [BTW-1:0] BIT_MAX = BTW'(BW - 1);

  src_e          src_now, src_cur, src_q;
  logic [BW-1:0] byte_now, byte_cur, byte_q;
  logic          out_d;

  // source choice for the timeslot that starts now
  always_comb begin
    if (code_en_i[ch_i]) begin
      src_now  = SRC_CODE;
      byte_now = codes_i[ch_i];
    end else if (idle_en_i[ch_i]) begin
      src_now  = lb_mode_i ? SRC_LB : SRC_IDLE;
      byte_now = idle_code_i;
    end else begin
      src_now  = SRC_SER;
      byte_now = idle_code_i;
    end
    src_cur  = bound_i ? src_now  : src_q;
    byte_cur = bound_i ? byte_now : byte_q;
    unique case (src_cur)
      SRC_IDLE, SRC_CODE: out_d = byte_cur[BIT_MAX - bit_i];
      SRC_LB:             out_d = lb_i;
      default:            out_d = ser_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_SER;
      byte_q <= '0;
    end else if (bound_i) begin
      src_q  <= src_now;
      byte_q <= byte_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_o <= 1'b0;
    end else begin
      ser_o <= out_d;
    end
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bound_i |=> ($stable(src_q) && $stable(byte_q))); // R7
  AST_PASS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (src_cur == SRC_SER) |=> (ser_o == $past(ser_i))); // R8
  AST_LB_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (src_cur == SRC_LB) |=> (ser_o == $past(lb_i))); // R6
endmodule

// File: rtl/e1_code_inserter.sv
module e1_code_inserter #(
  parameter int NCH = e1ci_pkg::NUM_CH,
  parameter int BW  = e1ci_pkg::BYTE_W,
  parameter int AW  = e1ci_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  input  logic          ser_in,
  input  logic          lb_in,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [BW-1:0] wr_data,
  output logic          ser_out
);
  localparam int CHW = $clog2(NCH);
  localparam int BTW = $clog2(BW);

  logic [CHW-1:0]         ch;
  logic [BTW-1:0]         bitpos;
  logic                   bound;
  logic [NCH-1:0]         idle_en, code_en;
  logic [BW-1:0]          idle_code;
  logic                   lb_mode;
  logic [NCH-1:0][BW-1:0] codes;

  e1ci_slot_cnt #(.NCH(NCH), .BW(BW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .fsync_i (fsync),
    .ch_o    (ch),
    .bit_o   (bitpos),
    .bound_o (bound)
  );

  e1ci_regfile #(.NCH(NCH), .BW(BW), .AW(AW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .idle_en_o   (idle_en),
    .code_en_o   (code_en),
    .idle_code_o (idle_code),
    .lb_mode_o   (lb_mode),
    .codes_o     (codes)
  );

  e1ci_byte_sel #(.NCH(NCH), .BW(BW)) u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .bound_i     (bound),
    .ch_i        (ch),
    .bit_i       (bitpos),
    .idle_en_i   (idle_en),
    .code_en_i   (code_en),
    .idle_code_i (idle_code),
    .lb_mode_i   (lb_mode),
    .codes_i     (codes),
    .ser_i       (ser_in),
    .lb_i        (lb_in),
    .ser_o       (ser_out)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !ser_out); // R1
endmodule

// File: tb/tb_e1_code_inserter.sv
`timescale 1ns/1ps
module tb_e1_code_inserter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0, ser_in = 1'b0, lb_in = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic       ser_out;

  always #2.5 clk = ~clk;

  e1_code_inserter dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .ser_in(ser_in), .lb_in(lb_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ser_out(ser_out)
  );

  int n_chk = 0, n_fail = 0;
  logic  exp_q[$];
  string tag_q[$];
  bit    mon_on = 1'b0;

  // reference model state
  bit         m_ien[32], m_cen[32], m_lb;
  logic [7:0] m_idle, m_code[32];
  int         m_bit = 0, m_ch = 0, s_src = 0;
  logic [7:0] s_byte = '0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s ser_out=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h1B) m_lb = d[5];
    else if (a >= 8'h22 && a <= 8'h25) for (int i = 0; i < 8; i++) m_cen[(a-8'h22)*8+i] = d[i];
    else if (a >= 8'h26 && a <= 8'h29) for (int i = 0; i < 8; i++) m_ien[(a-8'h26)*8+i] = d[i];
    else if (a == 8'h2A) m_idle = d;
    else if (a >= 8'h60 && a <= 8'h7F) m_code[a-8'h60] = d;
  endtask

  // driver: one cycle of stimulus, expected bit pushed to the scoreboard
  task automatic drive(input bit fs, input bit we, input logic [7:0] a,
                       input logic [7:0] d, input string tag);
    int pb, pc;
    logic e;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    fsync = fs; wr_en = we; wr_addr = a; wr_data = d;
    ser_in = lfsr[0]; lb_in = lfsr[7];
    pb = fs ? 0 : m_bit;
    pc = fs ? 0 : m_ch;
    if (pb == 0) begin
      if (m_cen[pc]) begin s_src = 2; s_byte = m_code[pc]; end
      else if (m_ien[pc]) begin s_src = m_lb ? 3 : 1; s_byte = m_idle; end
      else s_src = 0;
    end
    case (s_src)
      1, 2:    e = s_byte[7-pb];
      3:       e = lb_in;
      default: e = ser_in;
    endcase
    exp_q.push_back(e);
    tag_q.push_back(tag);
    m_bit = (pb == 7) ? 0 : pb + 1;
    m_ch  = (pb == 7) ? ((pc == 31) ? 0 : pc + 1) : pc;
    if (we) model_write(a, d);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(0, 0, 8'h00, 8'h00, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    drive(0, 1, a, d, tag);
  endtask

  // monitor: pops one expected bit per clock, sampled after the edge
  always begin
    @(posedge clk);
    #2;
    if (mon_on && exp_q.size() > 0) check(ser_out, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_lb = 0; m_idle = '0;
    for (int i = 0; i < 32; i++) begin m_ien[i] = 0; m_cen[i] = 0; m_code[i] = '0; end

    // R1: output quiet in reset even with active inputs
    ser_in = 1'b1; lb_in = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(ser_out, 1'b0, "R1");
    end
    @(posedge clk);
    #1 rst_n = 1'b1;
    mon_on = 1'b1;
    run(16, "R1");
    run(64, "R8");

    // R3: idle insertion, alignment by frame sync
    wr(8'h2A, 8'hA5, "R3");
    wr(8'h26, 8'h01, "R3");
    wr(8'h27, 8'h10, "R3");
    wr(8'h29, 8'h80, "R3");
    drive(1, 0, 8'h00, 8'h00, "R2");
    run(512, "R3");
    // R2: realign in mid-byte
    run(100, "R2");
    drive(1, 0, 8'h00, 8'h00, "R2");
    run(300, "R2");

    // R4: per-timeslot codes
    for (int c = 0; c < 32; c++) wr(8'(8'h60 + c), 8'(c * 37 + 5), "R4");
    wr(8'h24, 8'hFF, "R4");
    drive(1, 0, 8'h00, 8'h00, "R4");
    run(512, "R4");

    // R5: code over idle on timeslot 1 and 13
    wr(8'h22, 8'h01, "R5");
    wr(8'h23, 8'h10, "R5");
    run(512, "R5");

    // R6: loopback mode, code still wins where enabled
    wr(8'h1B, 8'h20, "R6");
    wr(8'h28, 8'h0F, "R6");
    run(768, "R6");
    wr(8'h1B, 8'h00, "R6");
    run(256, "R6");

    // R7: a write on every cycle, many hitting first-bit cycles
    for (int k = 0; k < 1024; k++) begin
      logic [7:0] a;
      case (k % 6)
        0: a = 8'h2A;
        1: a = 8'(8'h60 + (k * 7) % 32);
        2: a = 8'(8'h22 + (k / 6) % 4);
        3: a = 8'(8'h26 + (k / 6) % 4);
        4: a = 8'h1B;
        default: a = 8'(8'h60 + (k * 11) % 32);
      endcase
      drive((k % 389) == 200, 1, a, 8'(k * 73 + 11), "R7");
    end

    // R9: unmapped addresses and other control bits
    wr(8'h26, 8'hFF, "R9"); wr(8'h27, 8'hFF, "R9");
    wr(8'h28, 8'hFF, "R9"); wr(8'h29, 8'hFF, "R9");
    wr(8'h22, 8'h00, "R9"); wr(8'h23, 8'h00, "R9");
    wr(8'h24, 8'h00, "R9"); wr(8'h25, 8'h00, "R9");
    wr(8'h1B, 8'h00, "R9"); wr(8'h2A, 8'h3C, "R9");
    foreach (m_code[i]) wr(8'(8'h60 + i), 8'hC3, "R9");
    for (int k = 0; k < 512; k++) begin
      logic [7:0] a;
      case (k % 6)
        0: a = 8'h00; 1: a = 8'h21; 2: a = 8'h2B;
        3: a = 8'h80; 4: a = 8'hFF; default: a = 8'h1B;
      endcase
      drive(0, 1, a, (a == 8'h1B) ? 8'hDF : 8'(k * 29 + 1), "R9");
    end
    run(8, "R9");

    wait (exp_q.size() == 0);
    @(posedge clk);
    #3;
    finish_run();
  end
endmodule